// File: doc/BRIEF.md
# UART Oversampling Baud Tick Generator

This block turns a fast system clock into the two timing strobes a UART needs. A programmable modulo counter runs on the system clock and produces a one-cycle strobe at sixteen times the baud rate. A second, four-bit phase counter advances on every one of those strobes. When it wraps, it marks the boundary of a serial bit with a one-cycle bit-rate strobe. The current sub-bit phase (0 to 15) is also driven out, so a receiver can pick its mid-bit sampling points.

The divisor is a 16-bit runtime input. Software or a neighbouring block computes it as the system clock divided by sixteen times the baud rate, rounded to the nearest integer. For example, a 16 MHz clock at 9600 baud gives 104. The same clock used for direct division without oversampling gives 1667. A new divisor is picked up only at the end of the count period in progress, so a change never produces a runt period. A low enable freezes all counting, and a synchronous reset restarts the whole chain.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `ovsTick` and `bitTick` read 0 and `phase` reads 0 after that edge. After `rst` falls with `en` high, the first `ovsTick` appears exactly N clock edges later, where N is the effective divisor.
- R2: With `en` held high, `ovsTick` pulses once every N clock cycles, where N is the effective divisor.
- R3: `phase` increases by one on the same edge as each `ovsTick` pulse and goes from 15 back to 0. It never changes on any other edge.
- R4: `bitTick` is high only in a cycle where `ovsTick` is also high and `phase` reads 0, meaning the phase has just wrapped. With `en` high, it pulses once every 16·N cycles.
- R5: A `divisor` value of 0 or 1 gives an effective divisor of 1, so `ovsTick` is high on every cycle while `en` is high.
- R6: A change on `divisor` does not shorten or lengthen the count period in progress. The new value sets the length of the period that starts after the next `ovsTick`.
- R7: While `en` is low, `ovsTick` and `bitTick` read 0 from the next cycle on, and `phase` holds. When `en` returns high, counting resumes from where it stopped, so the pulse in progress is delayed by exactly the number of cycles `en` was low.
- R8: Divisors above 255, up to 65535, are honoured exactly. For example, 1667 gives an `ovsTick` period of 1667 cycles.
- R9: For an effective divisor of 2 or more, every `ovsTick` pulse is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes both counters |
| divisor | input | 16 | Requested system cycles per oversample strobe |
| ovsTick | output | 1 | One-cycle strobe at 16x the baud rate |
| bitTick | output | 1 | One-cycle strobe at the baud rate |
| phase | output | 4 | Sub-bit phase, advanced by each `ovsTick` |

## Verification
All three outputs are registered. The cycle counter reaches its limit in cycle N−1 after the period starts, and the strobe and the phase update are both due on the edge that ends that cycle. The bench therefore counts clock edges from the falling edge on which reset is released or on which the stimulus changes. It samples every output on the falling clock edge, half a period after the edge that updated it. Expected periods, reset-to-first-pulse delays, enable-stall delays and divisor hand-over points are all computed from N and the number of edges counted, never from internal state.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Strobes from the control section to the divider datapath
  typedef struct packed {
    logic countEn;   // advance the cycle counter this edge
    logic wrap;      // counter at limit: clear it and reload the divisor
  } divCtrl_t;

  // Clamp a requested divisor so that 0 and 1 both mean "every cycle"
  function automatic logic [15:0] effDivisor(input logic [15:0] req);
    return (req < 16'd2) ? 16'd1 : req;
  endfunction

endpackage

// File: rtl/baud_div_datapath.sv
module baud_div_datapath
  import baud_tick_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  divCtrl_t         ctrl,
  output logic             atLimit
);

  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cycleCount;
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] sanitized;

  // Values 0 and 1 both give an effective divisor of 1
  always_comb begin
    sanitized = (divisor < (ONE + ONE)) ? ONE : divisor;
  end

  // activeDiv only reloads at a period boundary, so a mid-period
  // divisor change cannot corrupt the count in progress
  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCount <= '0;
      activeDiv  <= sanitized;
    end else if (ctrl.wrap) begin
      cycleCount <= '0;
      activeDiv  <= sanitized;
    end else if (ctrl.countEn) begin
      cycleCount <= cycleCount + ONE;
    end
  end

  // Last count of the period is activeDiv-1
  always_comb begin
    atLimit = (cycleCount == (activeDiv - ONE));
  end

endmodule

// File: rtl/baud_phase_ctrl.sv
module baud_phase_ctrl
  import baud_tick_pkg::*;
#(
  parameter int OVS_RATE = 16,
  parameter int PHASE_W  = $clog2(OVS_RATE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               atLimit,
  output divCtrl_t           ctrl,
  output logic               ovsTick,
  output logic               bitTick,
  output logic [PHASE_W-1:0] phase
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(OVS_RATE - 1);

  logic [PHASE_W-1:0] phaseReg;
  logic               ovsReg;
  logic               bitReg;
  logic               wrapNow;

  always_comb begin
    wrapNow      = en && atLimit;
    ctrl.countEn = en;
    ctrl.wrap    = wrapNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseReg <= '0;
      ovsReg   <= 1'b0;
      bitReg   <= 1'b0;
    end else begin
      ovsReg <= wrapNow;
      bitReg <= wrapNow && (phaseReg == LAST_PHASE);
      if (wrapNow) begin
        phaseReg <= (phaseReg == LAST_PHASE) ? '0 : phaseReg + 1'b1;
      end
    end
  end

  assign ovsTick = ovsReg;
  assign bitTick = bitReg;
  assign phase   = phaseReg;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OVS_RATE = 16,
  parameter int PHASE_W  = $clog2(OVS_RATE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [DIV_W-1:0]   divisor,
  output logic               ovsTick,
  output logic               bitTick,
  output logic [PHASE_W-1:0] phase
);

  divCtrl_t ctrlBus;
  logic     atLimit;

  baud_div_datapath #(.DIV_W(DIV_W)) datapath_i (
    .clk     (clk),
    .rst     (rst),
    .divisor (divisor),
    .ctrl    (ctrlBus),
    .atLimit (atLimit)
  );

  baud_phase_ctrl #(.OVS_RATE(OVS_RATE), .PHASE_W(PHASE_W)) control_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .atLimit (atLimit),
    .ctrl    (ctrlBus),
    .ovsTick (ovsTick),
    .bitTick (bitTick),
    .phase   (phase)
  );

endmodule

// File: rtl/baud_tick_gen_checker.sv
module baud_tick_gen_checker #(
  parameter int PHASE_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               ovsTick,
  input logic               bitTick,
  input logic [PHASE_W-1:0] phase
);

  AST_BIT_NEEDS_OVS: assert property (@(posedge clk) disable iff (rst)
    bitTick |-> ovsTick);  // R4

  AST_BIT_AT_PHASE_ZERO: assert property (@(posedge clk) disable iff (rst)
    bitTick |-> (phase == '0));  // R4

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ovsTick && !$past(rst)) |-> (phase == PHASE_W'($past(phase) + 1'b1)));  // R3

  AST_PHASE_ONLY_ON_OVS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(phase)) |-> ovsTick);  // R3

  AST_IDLE_NO_OVS: assert property (@(posedge clk) disable iff (rst)
    !en |=> !ovsTick);  // R7

  AST_IDLE_NO_BIT: assert property (@(posedge clk) disable iff (rst)
    !en |=> !bitTick);  // R7

  AST_IDLE_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase));  // R7

endmodule

bind baud_tick_gen baud_tick_gen_checker #(.PHASE_W(PHASE_W)) checker_i (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .ovsTick (ovsTick),
  .bitTick (bitTick),
  .phase   (phase)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic [15:0] divisor = 16'd104;
  logic        ovsTick;
  logic        bitTick;
  logic [3:0]  phase;

  int testCount = 0;
  int failCount = 0;
  int wdCycles  = 0;

  always #4 clk = ~clk;  // 125 MHz

  baud_tick_gen dut_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .divisor (divisor),
    .ovsTick (ovsTick),
    .bitTick (bitTick),
    .phase   (phase)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  always @(posedge clk) begin
    wdCycles++;
    if (wdCycles > 150000) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual %0d expected %0d", wdCycles, 150000);
      finishRun();
    end
  end

  // Reset with a given divisor, released on a falling edge
  task automatic doReset(input logic [15:0] div);
    @(negedge clk);
    rst = 1'b1;
    en = 1'b1;
    divisor = div;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Count falling edges until ovsTick is seen
  task automatic waitOvs(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!ovsTick && cnt < 70000);
  endtask

  task automatic testResetState();
    int n;
    @(negedge clk);
    rst = 1'b1;
    divisor = 16'd7;
    @(negedge clk);
    check(ovsTick == 0, "R1 ovsTick in reset", ovsTick, 0);
    check(bitTick == 0, "R1 bitTick in reset", bitTick, 0);
    check(phase == 0, "R1 phase in reset", phase, 0);
    @(negedge clk);
    rst = 1'b0;
    waitOvs(n);
    check(n == 7, "R1 first pulse delay", n, 7);
  endtask

  task automatic testPeriod104();
    int n;
    doReset(16'd104);
    waitOvs(n);
    check(n == 104, "R2 first period 104", n, 104);
    waitOvs(n);
    check(n == 104, "R2 second period 104", n, 104);
    check(phase == 2, "R3 phase after two pulses", phase, 2);
    @(negedge clk);
    check(ovsTick == 0, "R9 pulse one cycle wide", ovsTick, 0);
  endtask

  task automatic testPhaseAndBit();
    int n;
    int bitAt;
    doReset(16'd5);
    bitAt = 0;
    for (int k = 1; k <= 16; k++) begin
      waitOvs(n);
      check(n == 5, "R2 period 5", n, 5);
      check(phase == 4'(k % 16), "R3 phase step", phase, k % 16);
      if (bitTick) bitAt = k;
      if (k < 16) check(bitTick == 0, "R4 no bit before wrap", bitTick, 0);
    end
    check(bitAt == 16, "R4 bit on 16th pulse", bitAt, 16);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitTick && n < 1000);
    check(n == 80, "R4 bit period 16N", n, 80);
  endtask

  task automatic testSmallDivisors();
    int ones;
    for (int d = 0; d < 2; d++) begin
      doReset(16'(d));
      ones = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (ovsTick) ones++;
      end
      check(ones == 20, "R5 every cycle for 0/1", ones, 20);
      check(phase == 4'(20 % 16), "R5 phase after 20", phase, 4);
    end
  endtask

  task automatic testDivisorChange();
    int n;
    doReset(16'd10);
    repeat (3) @(negedge clk);
    divisor = 16'd4;
    waitOvs(n);
    check(n == 7, "R6 period in progress keeps old divisor", n + 3, 10);
    waitOvs(n);
    check(n == 4, "R6 next period uses new divisor", n, 4);
  endtask

  task automatic testEnable();
    int n;
    int heldPhase;
    doReset(16'd10);
    repeat (3) @(negedge clk);
    en = 1'b0;
    heldPhase = phase;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (ovsTick) check(0, "R7 no tick while idle", 1, 0);
    end
    check(phase == 4'(heldPhase), "R7 phase held", phase, heldPhase);
    en = 1'b1;
    waitOvs(n);
    check(n == 7, "R7 resume delayed by idle time", n + 8, 15);
    doReset(16'd1);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(ovsTick == 0, "R7 idle quiet at divisor 1", ovsTick, 0);
    en = 1'b1;
  endtask

  task automatic testResetMidRun();
    int n;
    doReset(16'd7);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(phase == 0 && ovsTick == 0 && bitTick == 0, "R1 mid-run reset clears",
          phase, 0);
    @(negedge clk);
    rst = 1'b0;
    waitOvs(n);
    check(n == 7, "R1 restart delay", n, 7);
  endtask

  task automatic testWideDivisor();
    int n;
    doReset(16'd1667);
    waitOvs(n);
    check(n == 1667, "R8 wide divisor 1667", n, 1667);
    waitOvs(n);
    check(n == 1667, "R8 wide divisor repeat", n, 1667);
    @(negedge clk);
    check(ovsTick == 0, "R9 single-cycle wide", ovsTick, 0);
  endtask

  initial begin
    testResetState();
    testPeriod104();
    testPhaseAndBit();
    testSmallDivisors();
    testDivisorChange();
    testEnable();
    testResetMidRun();
    testWideDivisor();
    finishRun();
  end

endmodule